// File: doc/BRIEF.md
# Relative Thermal Reading Aggregator

This block sits behind a host-side bus poller that collects thermal readings from up to four processors. Each reading is a signed 16-bit value that gives the distance below the processor's throttle point, so results are negative in normal operation. A processor may report one or two domains. For each processor the block keeps the hotter domain of every polling round and sums these values in a per-channel accumulator. At the end of a programmable smoothing window it averages the sum, takes the integer byte, adds a signed calibration offset, saturates the result and writes it to that channel's 8-bit value output. The values stay in the relative signed format and are never converted to an absolute temperature.

Error codes reported by a processor, and frames that the poller marks as failing their check sequence, are left out of the sum. They set sticky status flags. Each updated value is also compared with a shared low limit and a shared high limit. Any status flag pulls the active-low alert output low. Configuration comes in on plain input ports.

Top module: `thr_agg`

## Requirements
- R1: The number of active processors is `cpu_cnt + 1`. A reading tagged with processor index `rd_cpu` is accepted into channel `rd_cpu` only when `rd_cpu <= cpu_cnt`. Readings for higher indices change no value and no status flag. A polling round ends with the last domain of channel `cpu_cnt`.
- R2: When `dom2[c]` is 1, channel c takes domain 0 (`rd_dom=0`) and then domain 1. Only the larger signed reading of the two, which is the one nearer the throttle point, is used. When `dom2[c]` is 0, domain-1 readings for that channel are ignored and set no status flag.
- R3: With smoothing code k, one window spans 2^(k+SMOOTH_BASE) rounds. The value outputs change only on the reading that ends a window, and they hold their contents at all other times.
- R4: A channel result is bits [15:8] of the floor of (sum / reads), taken as a signed byte. The signed offset (1 per LSB) is added to it and the sum is saturated to -128..127 before it is stored.
- R5: A reading in the range 0x8000..0x8003 is an error code. It is left out of the hotter-domain choice, sets `st_data_err`, and is never written to a value. If no domain of a round is usable, zero is added to the sum.
- R6: A reading with `rd_fcs_bad` high is left out of the sum in the same way and sets `st_comm_err`.
- R7: When a value updates, `st_lim[c]` is set if the new value is signed-less than `lim_lo` or signed-greater than `lim_hi`. A value equal to a limit sets nothing.
- R8: Every status flag is sticky and is cleared only by `stat_clr`. A set event in the same cycle as a clear takes precedence.
- R9: `alert_n` is low exactly when any status flag is set.
- R10: While `en` is low, no reading is accepted. The accumulators, the hotter-domain state and the round count are cleared, and the values hold.
- R11: After reset all values are 0x00, all status flags are 0 and `alert_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global accumulation enable |
| cpu_cnt | input | 2 | Number of processors minus one |
| dom2 | input | NCH | Per-channel two-domain select |
| smooth_k | input | 3 | Smoothing code |
| ofs | input | 8*NCH | Signed offset per channel, channel c at [8c+7:8c] |
| lim_lo | input | 8 | Shared signed low limit |
| lim_hi | input | 8 | Shared signed high limit |
| stat_clr | input | 1 | Clears all status flags |
| rd_valid | input | 1 | Reading strobe from the poller |
| rd_cpu | input | 2 | Processor index of the reading |
| rd_dom | input | 1 | Domain index of the reading |
| rd_data | input | 16 | Signed relative reading |
| rd_fcs_bad | input | 1 | Poller flags a failed frame check |
| val | output | 8*NCH | Signed channel values, channel c at [8c+7:8c] |
| st_data_err | output | 1 | Sticky error-code flag |
| st_comm_err | output | 1 | Sticky frame-check flag |
| st_lim | output | NCH | Sticky per-channel limit flags |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench builds the block with NCH=4 and SMOOTH_BASE=1. A window of code 0 then closes after two rounds and code 1 after four. This makes it possible to watch values stay put part-way through a window, to hit floor rounding with an odd sum, and to saturate at both rails in a few dozen cycles. With all four channels present, a reading for an inactive processor index can be sent and shown to have no effect.

// File: rtl/thr_pkg.sv
package thr_pkg;
   localparam int RD_W  = 16;
   localparam int VAL_W = 8;
   localparam int K_W   = 3;

   localparam logic [RD_W-1:0] ERR_FIRST = 16'h8000;
   localparam logic [RD_W-1:0] ERR_LAST  = 16'h8003;

   function automatic logic is_err_code(input logic [RD_W-1:0] d);
      return (d >= ERR_FIRST) && (d <= ERR_LAST);
   endfunction

   // clamp a 10-bit signed sum into the signed byte range
   function automatic logic [VAL_W-1:0] sat_byte(input logic signed [9:0] v);
      if (v > 10'sd127)       return 8'h7F;
      else if (v < -10'sd128) return 8'h80;
      else                    return v[7:0];
   endfunction
endpackage

// File: rtl/thr_window.sv
module thr_window
   import thr_pkg::*;
#(
   parameter int SMOOTH_BASE = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           round_done,
   input  logic [K_W-1:0] smooth_k,
   output logic           win_end
);
   localparam int CNT_W = SMOOTH_BASE + (1 << K_W) + 1;

   logic [CNT_W-1:0] rounds;
   logic [CNT_W-1:0] last_idx;

   always_comb begin
      last_idx = (CNT_W'(1) << (int'(smooth_k) + SMOOTH_BASE)) - CNT_W'(1);
      win_end  = round_done && (rounds >= last_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rounds <= '0;
      else if (!en)        rounds <= '0;
      else if (round_done) rounds <= win_end ? '0 : rounds + CNT_W'(1);
   end
endmodule

// File: rtl/thr_chan.sv
module thr_chan
   import thr_pkg::*;
#(
   parameter int SMOOTH_BASE = 6,
   parameter int ACC_W       = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             chan_on,
   input  logic             take,
   input  logic             rd_dom,
   input  logic [RD_W-1:0]  rd_data,
   input  logic             rd_good,
   input  logic             two_dom,
   input  logic             win_end,
   input  logic [K_W-1:0]   smooth_k,
   input  logic [VAL_W-1:0] ofs,
   output logic [VAL_W-1:0] val,
   output logic             upd,
   output logic [VAL_W-1:0] nval
);
   logic signed [RD_W-1:0]  best;
   logic                    best_vld;
   logic signed [ACC_W-1:0] acc;

   logic                    is_last;
   logic                    cur_vld;
   logic                    pick_new;
   logic                    m_vld;
   logic signed [RD_W-1:0]  m_val;
   logic signed [ACC_W-1:0] addend;
   logic signed [ACC_W-1:0] acc_nxt;
   logic signed [ACC_W-1:0] fin_src;
   logic signed [ACC_W-1:0] avg;
   logic signed [9:0]       sum10;

   always_comb begin
      is_last  = (rd_dom == two_dom);
      cur_vld  = rd_dom && best_vld;
      pick_new = rd_good && (!cur_vld || ($signed(rd_data) > best));
      m_vld    = cur_vld || rd_good;
      m_val    = pick_new ? $signed(rd_data) : best;
      addend   = m_vld ? {{(ACC_W-RD_W){m_val[RD_W-1]}}, m_val} : '0;
      acc_nxt  = acc + addend;
      fin_src  = (take && is_last) ? acc_nxt : acc;
      avg      = fin_src >>> (int'(smooth_k) + SMOOTH_BASE);
      sum10    = $signed({{2{avg[15]}}, avg[15:8]}) + $signed({{2{ofs[7]}}, ofs});
      nval     = sat_byte(sum10);
      upd      = win_end && chan_on;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best     <= '0;
         best_vld <= 1'b0;
         acc      <= '0;
      end else if (!en) begin
         best_vld <= 1'b0;
         acc      <= '0;
      end else begin
         if (take) begin
            if (is_last) best_vld <= 1'b0;
            else begin
               best     <= m_val;
               best_vld <= m_vld;
            end
         end
         if (upd)                  acc <= '0;
         else if (take && is_last) acc <= acc_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val <= '0;
      else if (upd) val <= nval;
   end
endmodule

// File: rtl/thr_status.sv
module thr_status
   import thr_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 set_data,
   input  logic                 set_comm,
   input  logic [NCH-1:0]       upd,
   input  logic [NCH*VAL_W-1:0] nval,
   input  logic [VAL_W-1:0]     lim_lo,
   input  logic [VAL_W-1:0]     lim_hi,
   output logic                 st_data_err,
   output logic                 st_comm_err,
   output logic [NCH-1:0]       st_lim,
   output logic                 alert_n
);
   logic [NCH-1:0] lim_hit;

   for (genvar c = 0; c < NCH; c++) begin : g_cmp
      logic signed [VAL_W-1:0] v;
      assign v = $signed(nval[c*VAL_W +: VAL_W]);
      assign lim_hit[c] = upd[c] && ((v < $signed(lim_lo)) || (v > $signed(lim_hi)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_data_err <= 1'b0;
         st_comm_err <= 1'b0;
         st_lim      <= '0;
      end else begin
         st_data_err <= set_data || (st_data_err && !clr);
         st_comm_err <= set_comm || (st_comm_err && !clr);
         st_lim      <= lim_hit | (clr ? '0 : st_lim);
      end
   end

   assign alert_n = !(st_data_err || st_comm_err || (|st_lim));
endmodule

// File: rtl/thr_agg.sv
module thr_agg
   import thr_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int SMOOTH_BASE = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [1:0]           cpu_cnt,
   input  logic [NCH-1:0]       dom2,
   input  logic [2:0]           smooth_k,
   input  logic [NCH*8-1:0]     ofs,
   input  logic [7:0]           lim_lo,
   input  logic [7:0]           lim_hi,
   input  logic                 stat_clr,
   input  logic                 rd_valid,
   input  logic [1:0]           rd_cpu,
   input  logic                 rd_dom,
   input  logic [15:0]          rd_data,
   input  logic                 rd_fcs_bad,
   output logic [NCH*8-1:0]     val,
   output logic                 st_data_err,
   output logic                 st_comm_err,
   output logic [NCH-1:0]       st_lim,
   output logic                 alert_n
);
   localparam int ACC_W = RD_W + SMOOTH_BASE + (1 << K_W) + 1;

   if (NCH < 2 || NCH > 4) begin : g_bad_nch
      $error("thr_agg: NCH must lie in 2..4");
   end
   if (SMOOTH_BASE < 0 || SMOOTH_BASE > 10) begin : g_bad_base
      $error("thr_agg: SMOOTH_BASE must lie in 0..10");
   end

   logic           dom2_sel;
   logic           accept;
   logic           rd_good;
   logic           round_done;
   logic           win_end;
   logic [NCH-1:0] upd;
   logic [NCH*VAL_W-1:0] nval;

   always_comb begin
      dom2_sel = 1'b0;
      for (int i = 0; i < NCH; i++)
         if (int'(rd_cpu) == i) dom2_sel = dom2[i];
      accept     = en && rd_valid && (rd_cpu <= cpu_cnt) && (int'(rd_cpu) < NCH)
                   && (!rd_dom || dom2_sel);
      rd_good    = !is_err_code(rd_data) && !rd_fcs_bad;
      round_done = accept && (rd_cpu == cpu_cnt) && (rd_dom == dom2_sel);
   end

   thr_window #(.SMOOTH_BASE(SMOOTH_BASE)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .round_done(round_done),
      .smooth_k  (smooth_k),
      .win_end   (win_end)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic take_c;
      logic on_c;
      assign take_c = accept && (int'(rd_cpu) == c);
      assign on_c   = (c <= int'(cpu_cnt));

      thr_chan #(.SMOOTH_BASE(SMOOTH_BASE), .ACC_W(ACC_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en),
         .chan_on (on_c),
         .take    (take_c),
         .rd_dom  (rd_dom),
         .rd_data (rd_data),
         .rd_good (rd_good),
         .two_dom (dom2[c]),
         .win_end (win_end),
         .smooth_k(smooth_k),
         .ofs     (ofs[c*8 +: 8]),
         .val     (val[c*8 +: 8]),
         .upd     (upd[c]),
         .nval    (nval[c*VAL_W +: VAL_W])
      );
   end

   thr_status #(.NCH(NCH)) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (stat_clr),
      .set_data   (accept && is_err_code(rd_data)),
      .set_comm   (accept && rd_fcs_bad),
      .upd        (upd),
      .nval       (nval),
      .lim_lo     (lim_lo),
      .lim_hi     (lim_hi),
      .st_data_err(st_data_err),
      .st_comm_err(st_comm_err),
      .st_lim     (st_lim),
      .alert_n    (alert_n)
   );
endmodule

// File: rtl/thr_agg_chk.sv
module thr_agg_chk #(
   parameter int NCH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [1:0]       cpu_cnt,
   input logic             stat_clr,
   input logic             rd_valid,
   input logic [1:0]       rd_cpu,
   input logic             rd_dom,
   input logic [15:0]      rd_data,
   input logic             rd_fcs_bad,
   input logic [NCH*8-1:0] val,
   input logic             st_data_err,
   input logic             st_comm_err,
   input logic [NCH-1:0]   st_lim,
   input logic             alert_n
);
   logic dom0_in;
   assign dom0_in = en && rd_valid && !rd_dom && (rd_cpu <= cpu_cnt) && (int'(rd_cpu) < NCH);

   AST_ALERT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_n |-> (st_data_err || st_comm_err || (|st_lim))); // R9
   AST_FLAG_RAISES_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_data_err || st_comm_err || (|st_lim)) |-> !alert_n); // R9
   AST_DATA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_data_err && !stat_clr) |=> st_data_err); // R8
   AST_COMM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_comm_err && !stat_clr) |=> st_comm_err); // R8
   AST_LIM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((st_lim & $past(st_lim)) == $past(st_lim))); // R8
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(val)); // R10
   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(val)); // R3
   AST_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (dom0_in && rd_data >= 16'h8000 && rd_data <= 16'h8003) |=> st_data_err); // R5
   AST_FCS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (dom0_in && rd_fcs_bad) |=> st_comm_err); // R6
endmodule

bind thr_agg thr_agg_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .cpu_cnt    (cpu_cnt),
   .stat_clr   (stat_clr),
   .rd_valid   (rd_valid),
   .rd_cpu     (rd_cpu),
   .rd_dom     (rd_dom),
   .rd_data    (rd_data),
   .rd_fcs_bad (rd_fcs_bad),
   .val        (val),
   .st_data_err(st_data_err),
   .st_comm_err(st_comm_err),
   .st_lim     (st_lim),
   .alert_n    (alert_n)
);

// File: tb/tb_thr_agg.sv
module tb_thr_agg;
   localparam int NCH  = 4;
   localparam int BASE = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [1:0]       cpu_cnt = '0;
   logic [NCH-1:0]   dom2 = '0;
   logic [2:0]       smooth_k = '0;
   logic [NCH*8-1:0] ofs = '0;
   logic [7:0]       lim_lo = 8'h80;
   logic [7:0]       lim_hi = 8'h7F;
   logic             stat_clr = 1'b0;
   logic             rd_valid = 1'b0;
   logic [1:0]       rd_cpu = '0;
   logic             rd_dom = 1'b0;
   logic [15:0]      rd_data = '0;
   logic             rd_fcs_bad = 1'b0;
   logic [NCH*8-1:0] val;
   logic             st_data_err;
   logic             st_comm_err;
   logic [NCH-1:0]   st_lim;
   logic             alert_n;

   int total = 0;
   int bad   = 0;

   thr_agg #(.NCH(NCH), .SMOOTH_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cpu_cnt(cpu_cnt), .dom2(dom2),
      .smooth_k(smooth_k), .ofs(ofs), .lim_lo(lim_lo), .lim_hi(lim_hi),
      .stat_clr(stat_clr), .rd_valid(rd_valid), .rd_cpu(rd_cpu), .rd_dom(rd_dom),
      .rd_data(rd_data), .rd_fcs_bad(rd_fcs_bad), .val(val),
      .st_data_err(st_data_err), .st_comm_err(st_comm_err), .st_lim(st_lim),
      .alert_n(alert_n)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   // expected channel byte from the requirement: floor average, upper byte, offset, clamp
   function automatic int model(input int sum, input int shift, input int off);
      int a;
      int s;
      a = (sum >>> shift) >>> 8;
      s = a + off;
      if (s > 127)  s = 127;
      if (s < -128) s = -128;
      return s & 8'hFF;
   endfunction

   function automatic int sx(input logic [15:0] d);
      return int'($signed(d));
   endfunction

   function automatic int vch(input int c);
      return int'(val[c*8 +: 8]);
   endfunction

   task automatic send(input int cpu, input bit dom, input logic [15:0] d, input bit fb);
      rd_cpu = 2'(cpu); rd_dom = dom; rd_data = d; rd_fcs_bad = fb; rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0; rd_fcs_bad = 1'b0;
   endtask

   task automatic pulse_clr();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic t_reset();
      for (int c = 0; c < NCH; c++) chk("R11 value after reset", vch(c), 0);
      chk("R11 status after reset", {st_data_err, st_comm_err, st_lim}, 0);
      chk("R11 alert after reset", alert_n, 1);
   endtask

   task automatic t_basic();
      cpu_cnt = 0; dom2 = '0; smooth_k = 0;
      send(0, 0, 16'hF600, 0);
      chk("R3 no update mid-window", vch(0), 0);
      send(0, 0, 16'hF400, 0);
      chk("R4 basic average", vch(0), model(sx(16'hF600) + sx(16'hF400), BASE, 0));
   endtask

   task automatic t_domain();
      cpu_cnt = 1; dom2 = 4'b0001; smooth_k = 0;
      send(0, 0, 16'hF000, 0); send(0, 1, 16'hF800, 0);
      send(1, 0, 16'hE200, 0);
      send(1, 1, 16'h7F00, 1);
      chk("R2 ignored domain sets no flag", st_comm_err, 0);
      send(0, 0, 16'hFC00, 0); send(0, 1, 16'hE000, 0);
      send(1, 0, 16'hE200, 0);
      chk("R2 hotter domain kept", vch(0), model(sx(16'hF800) + sx(16'hFC00), BASE, 0));
      chk("R2 single-domain channel", vch(1), model(2 * sx(16'hE200), BASE, 0));
   endtask

   task automatic t_multi();
      cpu_cnt = 2; dom2 = '0; smooth_k = 0;
      ofs = {8'd0, 8'd100, 8'hFD, 8'd5};
      send(0, 0, 16'hEC00, 0); send(1, 0, 16'h8100, 0);
      send(3, 0, 16'h7000, 1);
      send(2, 0, 16'h3C00, 0);
      chk("R3 hold after one round", vch(0), model(sx(16'hF800) + sx(16'hFC00), BASE, 0));
      send(0, 0, 16'hEBFF, 0); send(1, 0, 16'h8100, 0); send(2, 0, 16'h3C00, 0);
      chk("R4 floor rounding with offset", vch(0), model(sx(16'hEC00) + sx(16'hEBFF), BASE, 5));
      chk("R4 saturate low", vch(1), 8'h80);
      chk("R4 saturate high", vch(2), 8'h7F);
      chk("R1 inactive channel unchanged", vch(3), 0);
      chk("R1 inactive channel sets no flag", st_comm_err, 0);
      ofs = '0;
   endtask

   task automatic t_window();
      cpu_cnt = 0; dom2 = '0; smooth_k = 1;
      send(0, 0, 16'hFC00, 0); send(0, 0, 16'hFC00, 0); send(0, 0, 16'hFC00, 0);
      chk("R3 code 1 holds after three rounds", vch(0), model(sx(16'hEC00) + sx(16'hEBFF), BASE, 5));
      send(0, 0, 16'hF800, 0);
      chk("R3 code 1 updates on fourth round", vch(0), model(3 * sx(16'hFC00) + sx(16'hF800), BASE + 1, 0));
      smooth_k = 0;
   endtask

   task automatic t_errors();
      cpu_cnt = 0; dom2 = 4'b0001; smooth_k = 0;
      pulse_clr();
      send(0, 0, 16'h8002, 0); send(0, 1, 16'hF000, 0);
      send(0, 0, 16'h8000, 0); send(0, 1, 16'h8003, 0);
      chk("R5 error code adds zero", vch(0), model(sx(16'hF000), BASE, 0));
      chk("R5 data error flag", st_data_err, 1);
      chk("R6 no comm flag yet", st_comm_err, 0);
      chk("R9 alert on data error", alert_n, 0);
      repeat (5) @(negedge clk);
      chk("R8 data flag sticky", st_data_err, 1);
      send(0, 0, 16'h0000, 1); send(0, 1, 16'hF800, 0);
      send(0, 0, 16'hF000, 0); send(0, 1, 16'hF000, 0);
      chk("R6 bad frame excluded", vch(0), model(sx(16'hF800) + sx(16'hF000), BASE, 0));
      chk("R6 comm error flag", st_comm_err, 1);
      pulse_clr();
      chk("R8 clear drops flags", {st_data_err, st_comm_err, st_lim}, 0);
      chk("R9 alert released", alert_n, 1);
   endtask

   task automatic t_limits();
      cpu_cnt = 2; dom2 = '0; smooth_k = 0;
      lim_lo = 8'hF0; lim_hi = 8'hFC;
      send(0, 0, 16'h0500, 0); send(1, 0, 16'hEC00, 0); send(2, 0, 16'hF000, 0);
      send(0, 0, 16'h0500, 0); send(1, 0, 16'hEC00, 0); send(2, 0, 16'hF000, 0);
      chk("R7 signed high and low hits, equal is clean", st_lim, 4'b0011);
      chk("R9 alert on limit", alert_n, 0);
      pulse_clr();
      chk("R8 limit flags cleared", st_lim, 0);
      lim_lo = 8'h80; lim_hi = 8'h7F;
   endtask

   task automatic t_enable();
      cpu_cnt = 0; dom2 = '0; smooth_k = 0;
      send(0, 0, 16'hD800, 0);
      en = 1'b0;
      send(0, 0, 16'h0000, 0);
      send(0, 0, 16'h0000, 0);
      chk("R10 value holds while off", vch(0), 8'h05);
      en = 1'b1;
      send(0, 0, 16'hFE00, 0);
      chk("R10 fresh window after enable", vch(0), 8'h05);
      send(0, 0, 16'hFE00, 0);
      chk("R10 accumulator cleared", vch(0), model(2 * sx(16'hFE00), BASE, 0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      en = 1'b1;
      t_basic();
      t_domain();
      t_multi();
      t_window();
      t_errors();
      t_limits();
      t_enable();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule